// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer

This block carries a 68k-style processor bus interface through the full response to an interrupt. It waits until two things are true in the same cycle: a non-zero request level is pending, and the core signals that it has reached an instruction boundary. It then asks the core to save its status register and program counter through a request/acknowledge handshake. After that it runs a CPU-space acknowledge cycle on the bus, with a fixed function code and a fixed address pattern that carries the level being served.

The cycle ends in one of three ways. A responder can return a vector number with a data-size acknowledge. An autovector request can make the block derive the vector from the level. Or a bus error can arrive, either from outside or from the block's own timeout monitor, and the block then substitutes the spurious vector. The chosen vector number is scaled by four and added to a vector base. The result is presented with a one-cycle completion pulse, and the core fetches its new program counter from that address. The priority field of the status register is loaded from the level bits of the acknowledge address.

Top module: `irq_ack_ctrl`

## Requirements
- R1: After reset, `stack_req_o`, `ack_cyc_o`, `done_o` and `berr_o` are 0, `fc_o` and `addr_o` are all zeros, and `sr_ipl_o` is 0.
- R2: The sequence starts only when `irq_level_i` is non-zero and `boundary_i` is 1 at the same clock edge. `stack_req_o` rises in the next cycle. A boundary with level 0, or a level with no boundary, starts nothing.
- R3: `stack_req_o` stays high until a clock edge at which `stack_ack_i` is 1. `ack_cyc_o` is high from the next cycle on.
- R4: While `ack_cyc_o` is high, `fc_o` = 3'b111. `addr_o` has all bits from the top down to bit 4 set to one, bits [3:1] hold the acknowledged level, and bit 0 is 1. Outside the cycle both are zero.
- R5: `sr_ipl_o` takes the value of `addr_o[3:1]` at the end of each acknowledge cycle and holds it afterwards.
- R6: If `dsack_i` is 1 at an acknowledge edge, the vector number is `data_vec_i`. This path wins over `avec_i` and over a bus error.
- R7: If `avec_i` is 1 (and `dsack_i` is 0), the vector number is 24 plus the acknowledged level.
- R8: If no acknowledge arrives, the cycle ends as spurious with vector 24. This happens either when `berr_i` is 1, or after exactly `tmo_limit_i`+1 cycles of `ack_cyc_o`. On a timeout, `berr_o` is high for only the last of those cycles.
- R9: `done_o` is a one-cycle pulse in the cycle after the terminating edge. At that point `vec_num_o` holds the vector and `vec_addr_o` = `vbr_i` + 4 × vector, modulo 2^32.
- R10: The level is captured at the start. Changes of `irq_level_i` during the sequence do not alter the address, the vector or `sr_ipl_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_level_i | input | 3 | Pending request level, 0 = none |
| boundary_i | input | 1 | Core is at an instruction boundary |
| stack_req_o | output | 1 | Request to save status register and PC |
| stack_ack_i | input | 1 | Save completed |
| ack_cyc_o | output | 1 | Acknowledge bus cycle in progress |
| fc_o | output | 3 | Function code |
| addr_o | output | ADDR_W | Address bus |
| dsack_i | input | 1 | Responder supplies a vector |
| data_vec_i | input | 8 | Vector number from the responder |
| avec_i | input | 1 | Autovector request |
| berr_i | input | 1 | External bus error |
| tmo_limit_i | input | TMO_W | Timeout limit in cycles |
| vbr_i | input | 32 | Vector base |
| berr_o | output | 1 | Bus error raised by the timeout monitor |
| done_o | output | 1 | Vector ready pulse |
| vec_num_o | output | 8 | Resolved vector number |
| vec_addr_o | output | 32 | Vector address |
| sr_ipl_o | output | 3 | Status-register priority field |

## Verification
The assertions assume that `vbr_i` does not change between the terminating edge and the completion pulse. They also assume that the handshake and termination inputs are driven only as single-cycle or level responses while the matching request is up. The bench changes `vbr_i` only while the block is idle. It raises `stack_ack_i`, `dsack_i`, `avec_i` and `berr_i` for exactly one cycle, inside the window where the block waits for them, and drops them again before the next stage. It sweeps every level against each termination path and several timeout limits.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

    localparam int LVL_W = 3;
    localparam int VEC_W = 8;
    localparam int FC_W  = 3;

    localparam logic [FC_W-1:0]  FC_CPU_SPACE = 3'b111;
    localparam logic [VEC_W-1:0] VEC_SPURIOUS = 8'd24;
    localparam logic [VEC_W-1:0] VEC_AUTO_BASE = 8'd24;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STACK,
        ST_ACK,
        ST_DONE
    } ack_state_e;

    typedef enum logic [1:0] {
        TERM_NONE,
        TERM_VEC,
        TERM_AUTO,
        TERM_SPUR
    } term_e;

    typedef struct packed {
        term_e             kind;
        logic [VEC_W-1:0]  num;
    } vec_result_t;

    function automatic logic [VEC_W-1:0] auto_vector(input logic [LVL_W-1:0] lvl);
        return VEC_AUTO_BASE + {{(VEC_W-LVL_W){1'b0}}, lvl};
    endfunction

endpackage

// File: rtl/ack_seq.sv
module ack_seq
    import irq_ack_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [LVL_W-1:0]    irq_level,
    input  logic                boundary,
    input  logic                stack_ack,
    input  logic                dsack,
    input  logic                avec,
    input  logic                berr_ext,
    input  logic [TMO_W-1:0]    tmo_limit,
    output ack_state_e          state,
    output logic [LVL_W-1:0]    lvl_q,
    output term_e               term,
    output logic                tmo_hit
);

    logic [TMO_W-1:0] tmo_cnt;

    // Timeout monitor: counts cycles spent in the acknowledge state.
    assign tmo_hit = (state == ST_ACK) && (tmo_cnt == tmo_limit);

    always_comb begin
        term = TERM_NONE;
        if (state == ST_ACK) begin
            if (dsack)                    term = TERM_VEC;
            else if (avec)                term = TERM_AUTO;
            else if (berr_ext || tmo_hit) term = TERM_SPUR;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            lvl_q   <= '0;
            tmo_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    tmo_cnt <= '0;
                    if (boundary && (irq_level != '0)) begin
                        lvl_q <= irq_level;
                        state <= ST_STACK;
                    end
                end
                ST_STACK: begin
                    tmo_cnt <= '0;
                    if (stack_ack) state <= ST_ACK;
                end
                ST_ACK: begin
                    if (term != TERM_NONE) begin
                        state   <= ST_DONE;
                        tmo_cnt <= '0;
                    end else begin
                        tmo_cnt <= tmo_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ack_bus_enc.sv
module ack_bus_enc
    import irq_ack_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic                active,
    input  logic [LVL_W-1:0]    lvl,
    output logic [FC_W-1:0]     fc,
    output logic [ADDR_W-1:0]   addr
);

    localparam int HI_W = ADDR_W - LVL_W - 1;

    logic [ADDR_W-1:0] pattern;

    generate
        if (HI_W > 0) begin : g_hi
            assign pattern = {{HI_W{1'b1}}, lvl, 1'b1};
        end else begin : g_nohi
            assign pattern = {lvl, 1'b1};
        end
    endgenerate

    assign fc   = active ? FC_CPU_SPACE : '0;
    assign addr = active ? pattern : '0;

endmodule

// File: rtl/vec_resolve.sv
module vec_resolve
    import irq_ack_pkg::*;
#(
    parameter int VADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  term_e               term,
    input  logic [VEC_W-1:0]    data_vec,
    input  logic [LVL_W-1:0]    lvl,
    input  logic [VADDR_W-1:0]  vbr,
    output logic [VEC_W-1:0]    vec_num,
    output logic [VADDR_W-1:0]  vec_addr
);

    vec_result_t res;

    always_comb begin
        res.kind = term;
        case (term)
            TERM_VEC:  res.num = data_vec;
            TERM_AUTO: res.num = auto_vector(lvl);
            default:   res.num = VEC_SPURIOUS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_num  <= '0;
            vec_addr <= '0;
        end else if (res.kind != TERM_NONE) begin
            vec_num  <= res.num;
            vec_addr <= vbr + {{(VADDR_W-VEC_W-2){1'b0}}, res.num, 2'b00};
        end
    end

endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
    import irq_ack_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int TMO_W   = 8,
    parameter int VADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          irq_level_i,
    input  logic                boundary_i,
    output logic                stack_req_o,
    input  logic                stack_ack_i,
    output logic                ack_cyc_o,
    output logic [2:0]          fc_o,
    output logic [ADDR_W-1:0]   addr_o,
    input  logic                dsack_i,
    input  logic [7:0]          data_vec_i,
    input  logic                avec_i,
    input  logic                berr_i,
    input  logic [TMO_W-1:0]    tmo_limit_i,
    input  logic [VADDR_W-1:0]  vbr_i,
    output logic                berr_o,
    output logic                done_o,
    output logic [7:0]          vec_num_o,
    output logic [VADDR_W-1:0]  vec_addr_o,
    output logic [2:0]          sr_ipl_o
);

    ack_state_e       state;
    logic [LVL_W-1:0] lvl_q;
    term_e            term;
    logic             tmo_hit;

    ack_seq #(.TMO_W(TMO_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .irq_level (irq_level_i),
        .boundary  (boundary_i),
        .stack_ack (stack_ack_i),
        .dsack     (dsack_i),
        .avec      (avec_i),
        .berr_ext  (berr_i),
        .tmo_limit (tmo_limit_i),
        .state     (state),
        .lvl_q     (lvl_q),
        .term      (term),
        .tmo_hit   (tmo_hit)
    );

    assign ack_cyc_o   = (state == ST_ACK);
    assign stack_req_o = (state == ST_STACK);
    assign done_o      = (state == ST_DONE);
    assign berr_o      = tmo_hit && !dsack_i && !avec_i;

    ack_bus_enc #(.ADDR_W(ADDR_W)) u_enc (
        .active (ack_cyc_o),
        .lvl    (lvl_q),
        .fc     (fc_o),
        .addr   (addr_o)
    );

    vec_resolve #(.VADDR_W(VADDR_W)) u_vec (
        .clk      (clk),
        .rst      (rst),
        .term     (term),
        .data_vec (data_vec_i),
        .lvl      (lvl_q),
        .vbr      (vbr_i),
        .vec_num  (vec_num_o),
        .vec_addr (vec_addr_o)
    );

    // Priority field is loaded from the level bits on the address bus.
    always_ff @(posedge clk) begin
        if (rst)            sr_ipl_o <= '0;
        else if (ack_cyc_o) sr_ipl_o <= addr_o[3:1];
    end

endmodule

// File: rtl/irq_ack_chk.sv
module irq_ack_chk #(
    parameter int ADDR_W  = 24,
    parameter int TMO_W   = 8,
    parameter int VADDR_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic [2:0]          irq_level_i,
    input logic                boundary_i,
    input logic                stack_req_o,
    input logic                stack_ack_i,
    input logic                ack_cyc_o,
    input logic [2:0]          fc_o,
    input logic [ADDR_W-1:0]   addr_o,
    input logic                dsack_i,
    input logic [7:0]          data_vec_i,
    input logic                avec_i,
    input logic                berr_i,
    input logic [TMO_W-1:0]    tmo_limit_i,
    input logic [VADDR_W-1:0]  vbr_i,
    input logic                berr_o,
    input logic                done_o,
    input logic [7:0]          vec_num_o,
    input logic [VADDR_W-1:0]  vec_addr_o,
    input logic [2:0]          sr_ipl_o
);

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(stack_req_o) |-> ($past(boundary_i) && ($past(irq_level_i) != 3'd0)));

    p_stack_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (stack_req_o && !stack_ack_i) |=> stack_req_o);

    p_stack_to_ack_r3: assert property (@(posedge clk) disable iff (rst)
        (stack_req_o && stack_ack_i) |=> ack_cyc_o);

    p_cpu_space_r4: assert property (@(posedge clk) disable iff (rst)
        ack_cyc_o |-> (fc_o == 3'b111 && addr_o[0] && addr_o[ADDR_W-1]));

    p_ipl_latch_r5: assert property (@(posedge clk) disable iff (rst)
        ack_cyc_o |=> (sr_ipl_o == $past(addr_o[3:1])));

    p_dsack_r6: assert property (@(posedge clk) disable iff (rst)
        (ack_cyc_o && dsack_i) |=> (done_o && vec_num_o == $past(data_vec_i)));

    p_berr_in_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        berr_o |-> ack_cyc_o);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_vec_addr_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (vec_addr_o == vbr_i + {vec_num_o, 2'b00}));

    p_one_phase_r3: assert property (@(posedge clk) disable iff (rst)
        $countones({stack_req_o, ack_cyc_o, done_o}) <= 1);

endmodule

bind irq_ack_ctrl irq_ack_chk #(
    .ADDR_W  (ADDR_W),
    .TMO_W   (TMO_W),
    .VADDR_W (VADDR_W)
) u_chk (.*);

// File: tb/irq_ack_ctrl_tb.sv
module irq_ack_ctrl_tb;

    localparam int ADDR_W  = 24;
    localparam int TMO_W   = 8;
    localparam int VADDR_W = 32;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [2:0]         irq_level_i = '0;
    logic               boundary_i = 1'b0;
    logic               stack_req_o;
    logic               stack_ack_i = 1'b0;
    logic               ack_cyc_o;
    logic [2:0]         fc_o;
    logic [ADDR_W-1:0]  addr_o;
    logic               dsack_i = 1'b0;
    logic [7:0]         data_vec_i = '0;
    logic               avec_i = 1'b0;
    logic               berr_i = 1'b0;
    logic [TMO_W-1:0]   tmo_limit_i = 8'd40;
    logic [VADDR_W-1:0] vbr_i = 32'h0000_1000;
    logic               berr_o;
    logic               done_o;
    logic [7:0]         vec_num_o;
    logic [VADDR_W-1:0] vec_addr_o;
    logic [2:0]         sr_ipl_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    irq_ack_ctrl #(.ADDR_W(ADDR_W), .TMO_W(TMO_W), .VADDR_W(VADDR_W)) u_dut (
        .clk(clk), .rst(rst), .irq_level_i(irq_level_i), .boundary_i(boundary_i),
        .stack_req_o(stack_req_o), .stack_ack_i(stack_ack_i), .ack_cyc_o(ack_cyc_o),
        .fc_o(fc_o), .addr_o(addr_o), .dsack_i(dsack_i), .data_vec_i(data_vec_i),
        .avec_i(avec_i), .berr_i(berr_i), .tmo_limit_i(tmo_limit_i), .vbr_i(vbr_i),
        .berr_o(berr_o), .done_o(done_o), .vec_num_o(vec_num_o),
        .vec_addr_o(vec_addr_o), .sr_ipl_o(sr_ipl_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] exp_addr(input logic [2:0] l);
        return {{(ADDR_W-4){1'b1}}, l, 1'b1};
    endfunction

    // path: 0 dsack, 1 avec, 2 dsack+avec, 3 external berr, 4 timeout
    task automatic run_seq(input logic [2:0] lvl, input int path, input int sdly,
                           input logic [7:0] lim);
        logic [7:0]  ev;
        logic [7:0]  dv;
        int          n;
        dv = 8'd64 + {2'b00, lvl, 3'b000} + 8'(path);
        tmo_limit_i = lim;
        irq_level_i = lvl;
        boundary_i  = 1'b1;
        @(negedge clk);
        boundary_i  = 1'b0;
        irq_level_i = lvl ^ 3'b101;   // R10: later changes must be ignored
        chk(stack_req_o && !ack_cyc_o, "R2 stack_req after start", 32'(stack_req_o), 1);
        for (int i = 0; i < sdly; i++) begin
            @(negedge clk);
            chk(stack_req_o && !ack_cyc_o, "R3 stack_req held", 32'(stack_req_o), 1);
        end
        stack_ack_i = 1'b1;
        @(negedge clk);
        stack_ack_i = 1'b0;
        chk(ack_cyc_o && !stack_req_o, "R3 ack cycle begins", 32'(ack_cyc_o), 1);
        chk(fc_o == 3'b111, "R4 function code", 32'(fc_o), 32'h7);
        chk(addr_o == exp_addr(lvl), "R4/R10 address pattern", 32'(addr_o),
            32'(exp_addr(lvl)));
        case (path)
            0: begin dsack_i = 1'b1; data_vec_i = dv; ev = dv; end
            1: begin avec_i = 1'b1; ev = 8'd24 + {5'd0, lvl}; end
            2: begin dsack_i = 1'b1; avec_i = 1'b1; data_vec_i = dv; ev = dv; end
            3: begin berr_i = 1'b1; ev = 8'd24; end
            default: ev = 8'd24;
        endcase
        if (path == 4) begin
            n = 0;
            while (ack_cyc_o && n < 300) begin
                n++;
                chk(berr_o == (n == int'(lim) + 1), "R8 berr_o only on last cycle",
                    32'(berr_o), 32'(n == int'(lim) + 1));
                @(negedge clk);
            end
            chk(n == int'(lim) + 1, "R8 timeout length", n, int'(lim) + 1);
        end else begin
            chk(!berr_o, "R8 no monitor berr before timeout", 32'(berr_o), 0);
            @(negedge clk);
            dsack_i = 1'b0; avec_i = 1'b0; berr_i = 1'b0;
        end
        chk(done_o && !ack_cyc_o, "R9 done pulse", 32'(done_o), 1);
        case (path)
            0, 2: chk(vec_num_o == ev, "R6 supplied vector", 32'(vec_num_o), 32'(ev));
            1:    chk(vec_num_o == ev, "R7 autovector", 32'(vec_num_o), 32'(ev));
            default: chk(vec_num_o == ev, "R8 spurious vector", 32'(vec_num_o), 32'(ev));
        endcase
        chk(vec_addr_o == vbr_i + {22'd0, ev, 2'b00}, "R9 vector address",
            vec_addr_o, vbr_i + {22'd0, ev, 2'b00});
        chk(sr_ipl_o == lvl, "R5 priority field", 32'(sr_ipl_o), 32'(lvl));
        chk(fc_o == 3'd0 && addr_o == '0, "R4 bus idle after cycle", 32'(addr_o), 0);
        irq_level_i = 3'd0;
        @(negedge clk);
        chk(!done_o && !stack_req_o, "R9 done one cycle", 32'(done_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(!stack_req_o && !ack_cyc_o && !done_o && !berr_o, "R1 control outputs",
            {stack_req_o, ack_cyc_o, done_o, berr_o}, 0);
        chk(fc_o == 0 && addr_o == 0 && sr_ipl_o == 0, "R1 bus and priority",
            32'(addr_o), 0);

        // R2: boundary without level, level without boundary
        boundary_i = 1'b1;
        @(negedge clk);
        chk(!stack_req_o, "R2 boundary with level 0", 32'(stack_req_o), 0);
        boundary_i = 1'b0;
        irq_level_i = 3'd6;
        repeat (2) @(negedge clk);
        chk(!stack_req_o, "R2 level without boundary", 32'(stack_req_o), 0);
        irq_level_i = 3'd0;

        for (int l = 1; l < 8; l++) begin
            for (int p = 0; p < 4; p++) begin
                run_seq(3'(l), p, (l + p) % 3, 8'd40);
            end
            vbr_i = vbr_i + 32'h0010_0404;
        end

        // R8 timeout limits
        run_seq(3'd3, 4, 0, 8'd0);
        run_seq(3'd7, 4, 1, 8'd1);
        run_seq(3'd1, 4, 2, 8'd5);
        run_seq(3'd5, 4, 0, 8'd17);

        // R9 address wrap with high base
        vbr_i = 32'hFFFF_FFF0;
        run_seq(3'd2, 1, 0, 8'd40);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule